// File: doc/BRIEF.md
# Multi-Mode Down-Counter Channel

This block is one channel of a programmable interval timer. A 16-bit down-counter runs on the channel clock and drives a single output line, `out_o`. Each count write supplies an operating mode, a decimal-or-binary flag and a start value in the same cycle. The channel has six modes:

- terminal-count flag
- retriggerable one-shot
- periodic rate pulse
- square wave
- software-started strobe
- gate-started strobe

Each mode has its own output waveform and its own rule for when a freshly written value reaches the counting element. The live count, the output state and a flag marking a written but not yet used value can all be read at the ports.

A finite state machine sequences the channel:

- **IDLE**: the state after reset.
- **LOAD**: a value has been written and is transferred on the next edge.
- **WAIT**: the channel is waiting for a rising gate.
- **RUN**: the channel is counting.
- **DONE**: terminal count has been reached and the channel holds.

Transitions:

- **write→LOAD** happens in modes 0, 2, 3 and 4. **write→WAIT** happens in modes 1 and 5.
- **LOAD→RUN** is the transfer edge.
- **WAIT→RUN** and **DONE→RUN** happen on a trigger.
- **RUN→DONE** happens at terminal count in modes 0, 1, 4 and 5.
- Modes 2 and 3 reload inside RUN and never reach DONE.

A write made in the same mode while that mode is RUN (modes 2 and 3) or RUN/WAIT/DONE (modes 1 and 5) does not change state. It only replaces the pending value.

Top module: `timer_channel`

## Requirements
- R1: After reset `out_o`=0, `count_o`=0 and `null_o`=0.
- R2: The edge that samples `cnt_wr`=1 sets `null_o`. It drives `out_o` low if `cfg_mode`=0 and high for any other mode. The edge that moves the value into the counter clears `null_o`.
- R3: The count decrements in binary. A start value of 0 acts as 65536, so the count after 0 is 16'hFFFF.
- R4: With `cfg_bcd`=1, each nibble is a decimal digit and the count goes down in decimal: 0100→0099, 0000→9999, and in mode 3 0010→0008.
- R5: Mode 0: the transfer edge is followed by one decrement per edge while `gate`=1, and counting is held while `gate`=0. The edge that takes the count from 1 to 0 raises `out_o`, and the count and `out_o` then stay fixed.
- R6: Mode 0: a write during counting holds the count on that edge, drives `out_o` low, and restarts from the new value on the next edge.
- R7: Mode 1: a rising `gate` loads the pending value and drives `out_o` low. The count then decrements every edge whatever the gate level, and `out_o` rises when the count reaches 0. A write in mode 1 changes nothing until the next rising `gate`.
- R8: Mode 2 with start value N≥2: `out_o` goes low for exactly one cycle every N enabled edges, at the edge where the count 1 is replaced by N.
- R9: Mode 2: a write while running does not disturb the current period, and the new value is used at the next reload. If the write lands on a reload edge, that reload still uses the old value and `null_o` stays set.
- R10: Mode 3 with N≥2: the count steps by 2, and `out_o` toggles at each reload. For even N each level lasts N/2 cycles. For odd N the high level lasts (N+1)/2 cycles and the low level (N-1)/2 cycles.
- R11: Mode 4: counting starts on the edge after the write. `out_o` stays high and goes low for exactly one cycle when the count reaches 0.
- R12: Mode 5: counting waits for a rising `gate` and then behaves like mode 4, with `out_o` low for one cycle when the count reaches 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate | input | 1 | Count enable (modes 0, 2, 3, 4) or trigger (modes 1, 5) |
| cfg_mode | input | 3 | Operating mode 0..5, taken on a write |
| cfg_bcd | input | 1 | 1 selects decimal counting, taken on a write |
| cnt_wr | input | 1 | One-cycle count write strobe |
| cnt_val | input | 16 | Start value, taken on a write |
| count_o | output | 16 | Live counting element |
| out_o | output | 1 | Channel output line |
| null_o | output | 1 | Written value not yet transferred |

## Verification
In mode 2, a count write and the period reload can fall on the same clock edge. The bench provokes this by asserting `cnt_wr` with a new value exactly in the cycle where the live count reads 1. It then checks three things: the reload on that edge restores the old value, `out_o` still gives its one-cycle low pulse, and `null_o` stays high until the following period's reload picks up the new value. A mode 1 write while the channel holds in DONE is also checked, to show that the pending value waits for the next rising gate.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_RUN,
        ST_DONE
    } tc_state_e;

    localparam logic [2:0] MD_TERM     = 3'd0;
    localparam logic [2:0] MD_ONESHOT  = 3'd1;
    localparam logic [2:0] MD_RATE     = 3'd2;
    localparam logic [2:0] MD_SQUARE   = 3'd3;
    localparam logic [2:0] MD_SWSTROBE = 3'd4;
    localparam logic [2:0] MD_HWSTROBE = 3'd5;

endpackage

// File: rtl/tc_dec_stage.sv
module tc_dec_stage #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] val_i,
    input  logic             bcd_i,
    output logic [CNT_W-1:0] val_o
);
    localparam int NDIG = CNT_W / 4;

    logic [NDIG:0]      borrow;
    logic [CNT_W-1:0]   dec_res;

    assign borrow[0] = 1'b1;

    for (genvar d = 0; d < NDIG; d++) begin : g_digit
        logic [3:0] dig;
        assign dig = val_i[4*d +: 4];
        assign borrow[d+1] = borrow[d] & (dig == 4'd0);
        assign dec_res[4*d +: 4] = !borrow[d]    ? dig :
                                   (dig == 4'd0) ? 4'd9 : dig - 4'd1;
    end

    assign val_o = bcd_i ? dec_res : val_i - {{(CNT_W-1){1'b0}}, 1'b1};

endmodule

// File: rtl/tc_edge_detect.sv
module tc_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import tc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_bcd,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o,
    output logic             null_o
);
    localparam logic [CNT_W-1:0] C_ZERO = '0;
    localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_TWO  = CNT_W'(2);

    tc_state_e        state_q, state_d;
    logic [2:0]       mode_q, mode_d;
    logic             bcd_q, bcd_d;
    logic [CNT_W-1:0] pend_q, pend_d;
    logic [CNT_W-1:0] ce_q, ce_d;
    logic             skip_q, skip_d;
    logic             out_q, out_d;
    logic             null_q, null_d;

    logic             trig, en, keep, trig_mode;
    logic [CNT_W-1:0] dec1, dec2, pend_even;

    tc_edge_detect u_gate_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (gate),
        .rise_o (trig)
    );

    tc_dec_stage #(.CNT_W(CNT_W)) u_dec_a (.val_i(ce_q), .bcd_i(bcd_q), .val_o(dec1));
    tc_dec_stage #(.CNT_W(CNT_W)) u_dec_b (.val_i(dec1), .bcd_i(bcd_q), .val_o(dec2));

    assign trig_mode = (mode_q == MD_ONESHOT) || (mode_q == MD_HWSTROBE);
    assign en        = trig_mode ? 1'b1 : gate;
    assign pend_even = {pend_q[CNT_W-1:1], 1'b0};

    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        bcd_d   = bcd_q;
        pend_d  = pend_q;
        ce_d    = ce_q;
        skip_d  = skip_q;
        out_d   = out_q;
        null_d  = null_q;
        keep    = 1'b0;

        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: begin
                ce_d    = (mode_q == MD_SQUARE) ? pend_even : pend_q;
                skip_d  = (mode_q == MD_SQUARE) & pend_q[0];
                null_d  = 1'b0;
                state_d = ST_RUN;
            end
            ST_WAIT: begin
                if (trig) begin
                    ce_d    = pend_q;
                    null_d  = 1'b0;
                    state_d = ST_RUN;
                    if (mode_q == MD_ONESHOT) out_d = 1'b0;
                end
            end
            ST_RUN: begin
                if (trig_mode && trig) begin
                    ce_d   = pend_q;
                    null_d = 1'b0;
                    if (mode_q == MD_ONESHOT) out_d = 1'b0;
                end else begin
                    case (mode_q)
                        MD_TERM, MD_ONESHOT: begin
                            if (en) begin
                                if (ce_q == C_ONE) begin
                                    ce_d    = C_ZERO;
                                    out_d   = 1'b1;
                                    state_d = ST_DONE;
                                end else begin
                                    ce_d = dec1;
                                end
                            end
                        end
                        MD_SWSTROBE, MD_HWSTROBE: begin
                            if (en) begin
                                if (ce_q == C_ONE) begin
                                    ce_d    = C_ZERO;
                                    out_d   = 1'b0;
                                    state_d = ST_DONE;
                                end else begin
                                    ce_d = dec1;
                                end
                            end
                        end
                        MD_RATE: begin
                            out_d = 1'b1;
                            if (en) begin
                                if (ce_q == C_ONE) begin
                                    ce_d   = pend_q;
                                    null_d = 1'b0;
                                    out_d  = 1'b0;
                                end else begin
                                    ce_d = dec1;
                                end
                            end
                        end
                        MD_SQUARE: begin
                            if (en) begin
                                if (skip_q) begin
                                    skip_d = 1'b0;
                                end else if (ce_q == C_TWO) begin
                                    out_d  = ~out_q;
                                    ce_d   = pend_even;
                                    skip_d = ~out_q & pend_q[0];
                                    null_d = 1'b0;
                                end else begin
                                    ce_d = dec2;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_DONE: begin
                if (mode_q == MD_SWSTROBE || mode_q == MD_HWSTROBE) out_d = 1'b1;
                if (trig_mode && trig) begin
                    ce_d    = pend_q;
                    null_d  = 1'b0;
                    state_d = ST_RUN;
                    out_d   = (mode_q != MD_ONESHOT);
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (cnt_wr) begin
            pend_d = cnt_val;
            mode_d = cfg_mode;
            bcd_d  = cfg_bcd;
            null_d = 1'b1;
            keep   = (cfg_mode == mode_q) &&
                     ((((cfg_mode == MD_RATE) || (cfg_mode == MD_SQUARE)) && state_q == ST_RUN) ||
                      (((cfg_mode == MD_ONESHOT) || (cfg_mode == MD_HWSTROBE)) &&
                       (state_q == ST_RUN || state_q == ST_DONE || state_q == ST_WAIT)));
            if (!keep) begin
                ce_d    = ce_q;
                skip_d  = 1'b0;
                out_d   = (cfg_mode != MD_TERM);
                state_d = ((cfg_mode == MD_ONESHOT) || (cfg_mode == MD_HWSTROBE)) ? ST_WAIT : ST_LOAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_TERM;
            bcd_q  <= 1'b0;
            pend_q <= C_ZERO;
            ce_q   <= C_ZERO;
            skip_q <= 1'b0;
            out_q  <= 1'b0;
            null_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            bcd_q  <= bcd_d;
            pend_q <= pend_d;
            ce_q   <= ce_d;
            skip_q <= skip_d;
            out_q  <= out_d;
            null_q <= null_d;
        end
    end

    assign count_o = ce_q;
    assign out_o   = out_q;
    assign null_o  = null_q;

endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr,
    input logic [2:0]       mode_q,
    input logic [CNT_W-1:0] count_o,
    input logic             out_o,
    input logic             null_o
);
    AST_NULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> null_o); // R2

    AST_NULL_CLEAR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(null_o) |-> !$past(cnt_wr)); // R2

    AST_TERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd0 && out_o && !cnt_wr) |=> out_o); // R5

    AST_RATE_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd2 && !out_o && !cnt_wr && count_o != CNT_W'(1)) |=> out_o); // R8

    AST_SW_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out_o) && mode_q == 3'd4 && !cnt_wr) |=> out_o); // R11

    AST_HW_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out_o) && mode_q == 3'd5 && !cnt_wr) |=> out_o); // R12

endmodule

bind timer_channel tc_checker #(.CNT_W(CNT_W)) u_tc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_wr  (cnt_wr),
    .mode_q  (mode_q),
    .count_o (count_o),
    .out_o   (out_o),
    .null_o  (null_o)
);

// File: tb/timer_channel_tb.sv
module timer_channel_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic        cfg_bcd = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_val = 16'd0;
    logic [15:0] count_o;
    logic        out_o;
    logic        null_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          co;
        logic        xo;
        bit          cc;
        logic [15:0] xc;
        bit          cn;
        logic        xn;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_channel dut_i (
        .clk(clk), .rst_n(rst_n), .gate(gate), .cfg_mode(cfg_mode),
        .cfg_bcd(cfg_bcd), .cnt_wr(cnt_wr), .cnt_val(cnt_val),
        .count_o(count_o), .out_o(out_o), .null_o(null_o)
    );

    task automatic judge(input exp_t it);
        if (it.co) begin
            checks++;
            if (out_o !== it.xo) begin
                errors++;
                $display("FAIL %s out_o actual=%b expected=%b", it.tag, out_o, it.xo);
            end
        end
        if (it.cc) begin
            checks++;
            if (count_o !== it.xc) begin
                errors++;
                $display("FAIL %s count_o actual=%h expected=%h", it.tag, count_o, it.xc);
            end
        end
        if (it.cn) begin
            checks++;
            if (null_o !== it.xn) begin
                errors++;
                $display("FAIL %s null_o actual=%b expected=%b", it.tag, null_o, it.xn);
            end
        end
    endtask

    // monitor: pops expected items between edges
    always @(negedge clk) begin
        while (exp_q.size() > 0) judge(exp_q.pop_front());
    end

    task automatic drv(input logic g, input logic w, input logic [2:0] m,
                       input logic b, input logic [15:0] v);
        gate = g; cnt_wr = w; cfg_mode = m; cfg_bcd = b; cnt_val = v;
    endtask

    // one edge, then queue what the outputs must show after it
    task automatic cyc(input bit co, input logic xo, input bit cc, input logic [15:0] xc,
                       input bit cn, input logic xn, input string tag);
        exp_t it;
        @(posedge clk);
        it.co = co; it.xo = xo; it.cc = cc; it.xc = xc;
        it.cn = cn; it.xn = xn; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drv(0, 0, 0, 0, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_t r;
        do_reset();
        r.co = 1; r.xo = 0; r.cc = 1; r.xc = 0; r.cn = 1; r.xn = 0; r.tag = "R1";
        judge(r);

        // R5 mode 0 basic, R2 load/transfer
        drv(1, 1, 0, 0, 16'd4); cyc(1, 0, 0, 0, 1, 1, "R2 load mode0");
        drv(1, 0, 0, 0, 0);     cyc(1, 0, 1, 16'd4, 1, 0, "R2 transfer");
        cyc(1, 0, 1, 16'd3, 0, 0, "R5");
        cyc(1, 0, 1, 16'd2, 0, 0, "R5");
        cyc(1, 0, 1, 16'd1, 0, 0, "R5");
        cyc(1, 1, 1, 16'd0, 0, 0, "R5 terminal");
        cyc(1, 1, 1, 16'd0, 0, 0, "R5 hold");

        // R5 gate pause
        do_reset();
        drv(0, 1, 0, 0, 16'd3); cyc(1, 0, 0, 0, 1, 1, "R5 load");
        drv(0, 0, 0, 0, 0);     cyc(1, 0, 1, 16'd3, 1, 0, "R5 transfer gated");
        cyc(1, 0, 1, 16'd3, 0, 0, "R5 paused");
        cyc(1, 0, 1, 16'd3, 0, 0, "R5 paused");
        drv(1, 0, 0, 0, 0);
        cyc(1, 0, 1, 16'd2, 0, 0, "R5 resume");
        cyc(1, 0, 1, 16'd1, 0, 0, "R5");
        cyc(1, 1, 1, 16'd0, 0, 0, "R5 terminal");

        // R6 restart
        do_reset();
        drv(1, 1, 0, 0, 16'd5); cyc(0, 0, 0, 0, 0, 0, "R6");
        drv(1, 0, 0, 0, 0);     cyc(1, 0, 1, 16'd5, 0, 0, "R6");
        cyc(1, 0, 1, 16'd4, 0, 0, "R6");
        drv(1, 1, 0, 0, 16'd2); cyc(1, 0, 1, 16'd4, 1, 1, "R6 write holds");
        drv(1, 0, 0, 0, 0);     cyc(1, 0, 1, 16'd2, 1, 0, "R6 restart");
        cyc(1, 0, 1, 16'd1, 0, 0, "R6");
        cyc(1, 1, 1, 16'd0, 0, 0, "R6 terminal");

        // R7 one-shot
        do_reset();
        drv(0, 1, 1, 0, 16'd3); cyc(1, 1, 0, 0, 1, 1, "R7 load");
        drv(0, 0, 1, 0, 0);     cyc(1, 1, 0, 0, 1, 1, "R7 waiting");
        drv(1, 0, 1, 0, 0);     cyc(1, 0, 1, 16'd3, 1, 0, "R7 trigger");
        cyc(1, 0, 1, 16'd2, 0, 0, "R7");
        cyc(1, 0, 1, 16'd1, 0, 0, "R7");
        cyc(1, 1, 1, 16'd0, 0, 0, "R7 end");
        drv(1, 1, 1, 0, 16'd5); cyc(1, 1, 1, 16'd0, 1, 1, "R7 write no effect");
        drv(0, 0, 1, 0, 0);     cyc(1, 1, 1, 16'd0, 1, 1, "R7 still idle");
        drv(1, 0, 1, 0, 0);     cyc(1, 0, 1, 16'd5, 1, 0, "R7 retrigger");
        drv(0, 0, 1, 0, 0);     cyc(1, 0, 1, 16'd4, 0, 0, "R7 gate low ignored");
        cyc(1, 0, 1, 16'd3, 0, 0, "R7");

        // R8 / R9 rate
        do_reset();
        drv(1, 1, 2, 0, 16'd3); cyc(1, 1, 0, 0, 1, 1, "R8 load");
        drv(1, 0, 2, 0, 0);     cyc(1, 1, 1, 16'd3, 1, 0, "R8 transfer");
        cyc(1, 1, 1, 16'd2, 0, 0, "R8");
        cyc(1, 1, 1, 16'd1, 0, 0, "R8");
        cyc(1, 0, 1, 16'd3, 0, 0, "R8 pulse");
        cyc(1, 1, 1, 16'd2, 0, 0, "R8");
        cyc(1, 1, 1, 16'd1, 0, 0, "R8");
        cyc(1, 0, 1, 16'd3, 0, 0, "R8 pulse");
        drv(1, 1, 2, 0, 16'd4); cyc(1, 1, 1, 16'd2, 1, 1, "R9 deferred");
        drv(1, 0, 2, 0, 0);     cyc(1, 1, 1, 16'd1, 1, 1, "R9");
        cyc(1, 0, 1, 16'd4, 1, 0, "R9 new period");
        cyc(1, 1, 1, 16'd3, 0, 0, "R9");
        cyc(1, 1, 1, 16'd2, 0, 0, "R9");
        cyc(1, 1, 1, 16'd1, 0, 0, "R9");
        drv(1, 1, 2, 0, 16'd2); cyc(1, 0, 1, 16'd4, 1, 1, "R9 same edge old value");
        drv(1, 0, 2, 0, 0);     cyc(1, 1, 1, 16'd3, 1, 1, "R9");
        cyc(1, 1, 1, 16'd2, 0, 0, "R9");
        cyc(1, 1, 1, 16'd1, 0, 0, "R9");
        cyc(1, 0, 1, 16'd2, 1, 0, "R9 takes new");
        cyc(1, 1, 1, 16'd1, 0, 0, "R9");
        cyc(1, 0, 1, 16'd2, 0, 0, "R9 period 2");

        // R10 square even
        do_reset();
        drv(1, 1, 3, 0, 16'd4); cyc(1, 1, 0, 0, 1, 1, "R10 load");
        drv(1, 0, 3, 0, 0);     cyc(1, 1, 1, 16'd4, 1, 0, "R10");
        cyc(1, 1, 1, 16'd2, 0, 0, "R10");
        cyc(1, 0, 1, 16'd4, 0, 0, "R10 low");
        cyc(1, 0, 1, 16'd2, 0, 0, "R10");
        cyc(1, 1, 1, 16'd4, 0, 0, "R10 high");
        cyc(1, 1, 1, 16'd2, 0, 0, "R10");
        cyc(1, 0, 1, 16'd4, 0, 0, "R10 low");

        // R10 square odd
        do_reset();
        drv(1, 1, 3, 0, 16'd5); cyc(1, 1, 0, 0, 1, 1, "R10 odd load");
        drv(1, 0, 3, 0, 0);     cyc(1, 1, 1, 16'd4, 1, 0, "R10 odd");
        cyc(1, 1, 1, 16'd4, 0, 0, "R10 odd extra");
        cyc(1, 1, 1, 16'd2, 0, 0, "R10 odd");
        cyc(1, 0, 1, 16'd4, 0, 0, "R10 odd low");
        cyc(1, 0, 1, 16'd2, 0, 0, "R10 odd");
        cyc(1, 1, 1, 16'd4, 0, 0, "R10 odd high");
        cyc(1, 1, 1, 16'd4, 0, 0, "R10 odd");
        cyc(1, 1, 1, 16'd2, 0, 0, "R10 odd");
        cyc(1, 0, 1, 16'd4, 0, 0, "R10 odd low");

        // R11 software strobe
        do_reset();
        drv(1, 1, 4, 0, 16'd3); cyc(1, 1, 0, 0, 1, 1, "R11 load");
        drv(1, 0, 4, 0, 0);     cyc(1, 1, 1, 16'd3, 1, 0, "R11");
        cyc(1, 1, 1, 16'd2, 0, 0, "R11");
        cyc(1, 1, 1, 16'd1, 0, 0, "R11");
        cyc(1, 0, 1, 16'd0, 0, 0, "R11 strobe");
        cyc(1, 1, 1, 16'd0, 0, 0, "R11 one cycle");
        cyc(1, 1, 1, 16'd0, 0, 0, "R11 stays");

        // R12 hardware strobe
        do_reset();
        drv(0, 1, 5, 0, 16'd2); cyc(1, 1, 0, 0, 1, 1, "R12 load");
        drv(0, 0, 5, 0, 0);     cyc(1, 1, 0, 0, 1, 1, "R12 waiting");
        drv(1, 0, 5, 0, 0);     cyc(1, 1, 1, 16'd2, 1, 0, "R12 trigger");
        cyc(1, 1, 1, 16'd1, 0, 0, "R12");
        cyc(1, 0, 1, 16'd0, 0, 0, "R12 strobe");
        cyc(1, 1, 1, 16'd0, 0, 0, "R12 one cycle");

        // R3 zero start, binary
        do_reset();
        drv(1, 1, 0, 0, 16'd0); cyc(0, 0, 0, 0, 0, 0, "R3");
        drv(1, 0, 0, 0, 0);     cyc(0, 0, 1, 16'h0000, 1, 0, "R3");
        cyc(1, 0, 1, 16'hFFFF, 0, 0, "R3 wrap");

        // R4 decimal
        do_reset();
        drv(1, 1, 0, 1, 16'h0000); cyc(0, 0, 0, 0, 0, 0, "R4");
        drv(1, 0, 0, 1, 0);        cyc(0, 0, 1, 16'h0000, 0, 0, "R4");
        cyc(0, 0, 1, 16'h9999, 0, 0, "R4 decimal wrap");
        do_reset();
        drv(1, 1, 0, 1, 16'h0100); cyc(0, 0, 0, 0, 0, 0, "R4");
        drv(1, 0, 0, 1, 0);        cyc(0, 0, 1, 16'h0100, 0, 0, "R4");
        cyc(0, 0, 1, 16'h0099, 0, 0, "R4 borrow");
        do_reset();
        drv(1, 1, 3, 1, 16'h0010); cyc(0, 0, 0, 0, 0, 0, "R4");
        drv(1, 0, 3, 1, 0);        cyc(0, 0, 1, 16'h0010, 0, 0, "R4");
        cyc(0, 0, 1, 16'h0008, 0, 0, "R4 step two");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule